// File: doc/BRIEF.md
# Clause-22 Management Frame Engine

This block is the serial engine behind a station-management port. It takes one request: a read/write flag, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit data word. It then produces a complete management frame on a shared bidirectional data line, clocked by a management clock that it divides down from the system clock. The tri-state pad sits outside the block. The block drives it through a data-out and an output-enable pair and reads the pad back through a data-in pin.

A frame has these fields in order: a run of ones as preamble, the start pair 01, the opcode, the PHY address, the register address, two turnaround bits and sixteen data bits. Every field is sent MSB first. For a write, the master drives the whole frame, and the turnaround is a one followed by a zero. For a read, the master stops driving at the first turnaround bit. The bit after that tells the master whether a PHY answered: a responding PHY pulls the line low there. The sixteen data bits that follow are sampled on the rising edges of the management clock. A busy flag covers the frame. A single-cycle done pulse closes it. The read word and an acknowledge flag stay on the outputs until the next request replaces them.

The preamble length is a parameter, and zero removes the preamble entirely. The management-clock half period is also a parameter, counted in system clocks.

Top module: `mdio_frame_engine`

## Requirements
- R1: After reset, busy_o, done_o, mdc_o, mdio_oe_o and ack_o are 0 and rdata_o is 0. Whenever busy_o is 0, mdc_o and mdio_oe_o are 0.
- R2: The frame sends these fields in order: PRE_LEN ones, start bits 0 then 1, opcode 1,0 for a read (rd_i=1) or 0,1 for a write (rd_i=0), the 5-bit PHY address MSB first, then the 5-bit register address MSB first.
- R3: In a write frame, bits PRE_LEN+14 and PRE_LEN+15 are 1 then 0, followed by wdata_i MSB first. mdio_oe_o is 1 for every bit of the frame.
- R4: In a read frame, mdio_oe_o is 1 for bits 0 to PRE_LEN+13 and 0 from the first turnaround bit (bit PRE_LEN+14) to the end of the frame.
- R5: In a read frame, the 16 data bits are sampled from mdio_i on the rising edge of mdc_o, MSB first. The sampled word is on rdata_o by the cycle in which done_o is 1.
- R6: ack_o is 1 after a read only if mdio_i was sampled low in the second turnaround bit. Otherwise ack_o is 0 and rdata_o still takes the sampled word. Every accepted request clears ack_o.
- R7: While busy, mdc_o stays high for CLK_HALF system clocks and low for CLK_HALF system clocks. mdio_o changes only in the cycle where mdc_o falls.
- R8: After the falling mdc_o edge of the last bit, done_o is 1 for exactly one cycle. In that same cycle busy_o is 0 and the line is released.
- R9: A start_i pulse while busy_o is 1 is ignored. The frame in flight is unchanged, and only one done pulse follows.
- R10: A start_i pulse in the cycle done_o is 1 is accepted, and busy_o is 1 in the next cycle.
- R11: A write frame leaves rdata_o unchanged and ends with ack_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, taken when idle |
| rd_i | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Data word for a write |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse at frame end |
| rdata_o | output | 16 | Word captured by the last read |
| ack_o | output | 1 | The last read was answered |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data-line value to drive |
| mdio_oe_o | output | 1 | Data-line drive enable |
| mdio_i | input | 1 | Data-line value read back from the pad |

## Verification
The end of one frame and the acceptance of the next can land in the same system cycle. The done pulse and the falling busy flag appear together, and a new start can arrive on that same edge. The bench raises start_i exactly in the cycle where done_o is seen high. It then judges the overlap three ways: busy_o must return one cycle later, the first frame must have produced exactly one done pulse, and the second frame must carry the new request's opcode and addresses from its first preamble bit onward.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;

   localparam int unsigned ADDR_W = 5;
   localparam int unsigned DATA_W = 16;
   // start(2) + opcode(2) + two addresses + turnaround(2) + data
   localparam int unsigned BODY_W = 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
   // offset of the first turnaround bit inside the body
   localparam int unsigned TA_OFS = 2 + 2 + 2 * ADDR_W;

   localparam logic [1:0] SOF_BITS = 2'b01;
   localparam logic [1:0] OPC_RD   = 2'b10;
   localparam logic [1:0] OPC_WR   = 2'b01;
   localparam logic [1:0] TA_WR    = 2'b10;
   localparam logic [1:0] TA_RD    = 2'b11;

   typedef enum logic {
      SEQ_IDLE,
      SEQ_SHIFT
   } seq_state_e;

   typedef struct packed {
      logic              rd;
      logic [ADDR_W-1:0] phy;
      logic [ADDR_W-1:0] regn;
      logic [DATA_W-1:0] wdata;
   } mgmt_req_t;

   // Everything after the preamble; read frames put ones where the
   // released turnaround and data bits sit (drive is off there anyway).
   function automatic logic [BODY_W-1:0] frame_body(input mgmt_req_t q);
      return {SOF_BITS,
              q.rd ? OPC_RD : OPC_WR,
              q.phy,
              q.regn,
              q.rd ? TA_RD : TA_WR,
              q.rd ? {DATA_W{1'b1}} : q.wdata};
   endfunction

endpackage

// File: rtl/mdio_clk_div.sv
`timescale 1ns/1ps
module mdio_clk_div #(
   parameter int unsigned HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic mdc_o,
   output logic rise_stb_o,
   output logic fall_stb_o
);

   logic mdc_q;
   logic edge_now;

   generate
      if (HALF == 1) begin : g_div_toggle
         // fastest variant: no counter, toggle every system clock
         assign edge_now = run_i;
      end else begin : g_div_count
         localparam int unsigned CW = $clog2(HALF);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run_i || edge_now) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign edge_now = run_i && (cnt_q == CW'(HALF - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdc_q <= 1'b0;
      end else if (!run_i) begin
         mdc_q <= 1'b0;
      end else if (edge_now) begin
         mdc_q <= ~mdc_q;
      end
   end

   assign mdc_o      = mdc_q;
   assign rise_stb_o = edge_now && !mdc_q;
   assign fall_stb_o = edge_now &&  mdc_q;

endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
module mdio_frame_seq
   import mdio_pkg::*;
#(
   parameter int unsigned FRAME_W = 64,
   parameter int unsigned PRE_LEN = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               rd_i,
   input  logic [FRAME_W-1:0] frame_i,
   input  logic               rise_stb_i,
   input  logic               fall_stb_i,
   output logic               start_acc_o,
   output logic               busy_o,
   output logic               done_o,
   output logic               mdio_o,
   output logic               mdio_oe_o,
   output logic               samp_ack_o,
   output logic               samp_data_o
);

   localparam int unsigned IW       = $clog2(FRAME_W);
   localparam int unsigned TA_POS   = PRE_LEN + TA_OFS;
   localparam int unsigned TA2_POS  = TA_POS + 1;
   localparam int unsigned DATA_POS = TA_POS + 2;
   localparam int unsigned LAST_POS = FRAME_W - 1;

   seq_state_e        st_q;
   logic [FRAME_W-1:0] sr_q;
   logic [IW-1:0]      idx_q;
   logic               rd_q;
   logic               done_q;
   logic               last_bit;

   assign start_acc_o = start_i && (st_q == SEQ_IDLE);
   assign last_bit    = (idx_q == IW'(LAST_POS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SEQ_IDLE;
         sr_q   <= '0;
         idx_q  <= '0;
         rd_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            SEQ_IDLE: begin
               if (start_i) begin
                  st_q  <= SEQ_SHIFT;
                  sr_q  <= frame_i;
                  idx_q <= '0;
                  rd_q  <= rd_i;
               end
            end
            SEQ_SHIFT: begin
               if (fall_stb_i) begin
                  if (last_bit) begin
                     st_q   <= SEQ_IDLE;
                     done_q <= 1'b1;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                     sr_q  <= {sr_q[FRAME_W-2:0], 1'b0};
                  end
               end
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy_o      = (st_q == SEQ_SHIFT);
   assign done_o      = done_q;
   assign mdio_o      = busy_o ? sr_q[FRAME_W-1] : 1'b1;
   assign mdio_oe_o   = busy_o && !(rd_q && (idx_q >= IW'(TA_POS)));
   assign samp_ack_o  = busy_o && rd_q && rise_stb_i && (idx_q == IW'(TA2_POS));
   assign samp_data_o = busy_o && rd_q && rise_stb_i && (idx_q >= IW'(DATA_POS));

endmodule

// File: rtl/mdio_rx_capture.sv
`timescale 1ns/1ps
module mdio_rx_capture #(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          samp_ack_i,
   input  logic          samp_data_i,
   input  logic          mdio_i,
   output logic [DW-1:0] rdata_o,
   output logic          ack_o
);

   logic [DW-1:0] word_q;
   logic          ack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q <= 1'b0;
      end else if (clr_i) begin
         ack_q <= 1'b0;
      end else if (samp_ack_i) begin
         ack_q <= !mdio_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (samp_data_i) begin
         word_q <= {word_q[DW-2:0], mdio_i};
      end
   end

   assign rdata_o = word_q;
   assign ack_o   = ack_q;

endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
module mdio_frame_engine
   import mdio_pkg::*;
#(
   parameter int unsigned CLK_HALF = 2,
   parameter int unsigned PRE_LEN  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] phy_addr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              ack_o,
   output logic              mdc_o,
   output logic              mdio_o,
   output logic              mdio_oe_o,
   input  logic              mdio_i
);

   localparam int unsigned FRAME_W = PRE_LEN + BODY_W;

   initial begin : p_param_chk
      if (CLK_HALF < 1) $fatal(1, "CLK_HALF must be at least 1");
      if (PRE_LEN > 32) $fatal(1, "PRE_LEN must not exceed 32");
   end

   mgmt_req_t          req;
   logic [BODY_W-1:0]  body;
   logic [FRAME_W-1:0] frame;
   logic               start_acc;
   logic               rise_stb;
   logic               fall_stb;
   logic               samp_ack;
   logic               samp_data;

   assign req  = '{rd: rd_i, phy: phy_addr_i, regn: reg_addr_i, wdata: wdata_i};
   assign body = frame_body(req);

   generate
      if (PRE_LEN > 0) begin : g_with_pre
         assign frame = {{PRE_LEN{1'b1}}, body};
      end else begin : g_no_pre
         assign frame = body;
      end
   endgenerate

   mdio_clk_div #(.HALF(CLK_HALF)) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (busy_o),
      .mdc_o      (mdc_o),
      .rise_stb_o (rise_stb),
      .fall_stb_o (fall_stb)
   );

   mdio_frame_seq #(.FRAME_W(FRAME_W), .PRE_LEN(PRE_LEN)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .rd_i        (rd_i),
      .frame_i     (frame),
      .rise_stb_i  (rise_stb),
      .fall_stb_i  (fall_stb),
      .start_acc_o (start_acc),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .mdio_o      (mdio_o),
      .mdio_oe_o   (mdio_oe_o),
      .samp_ack_o  (samp_ack),
      .samp_data_o (samp_data)
   );

   mdio_rx_capture #(.DW(DATA_W)) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (start_acc),
      .samp_ack_i  (samp_ack),
      .samp_data_i (samp_data),
      .mdio_i      (mdio_i),
      .rdata_o     (rdata_o),
      .ack_o       (ack_o)
   );

endmodule

// File: rtl/mdio_frame_engine_chk.sv
`timescale 1ns/1ps
module mdio_frame_engine_chk #(
   parameter int unsigned CLK_HALF = 2
) (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic busy_o,
   input logic done_o,
   input logic ack_o,
   input logic mdc_o,
   input logic mdio_o,
   input logic mdio_oe_o,
   input logic mdio_i
);

   int unsigned hi_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hi_run <= 0;
      else        hi_run <= mdc_o ? hi_run + 1 : 0;
   end

   // R1: idle means clock parked low and line released
   a_r1_idle_parked: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!mdc_o && !mdio_oe_o));

   // R7: clock high phase never exceeds CLK_HALF cycles
   a_r7_mdc_high_len: assert property (@(posedge clk) disable iff (!rst_n)
      mdc_o |-> (hi_run < CLK_HALF));

   // R7: driven data moves only together with a falling clock
   a_r7_mdio_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o) && mdio_oe_o && $past(mdio_oe_o)
       && (mdio_o != $past(mdio_o))) |-> $fell(mdc_o));

   // R8: done is a single-cycle pulse
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8: done coincides with the end of busy
   a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   // R6: acknowledge rises only on a rising clock that sampled a low line
   a_r6_ack_from_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_o) |-> (!$past(mdio_i) && $rose(mdc_o)));

   // R10: a frame only begins after a request
   a_r10_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

endmodule

bind mdio_frame_engine mdio_frame_engine_chk #(.CLK_HALF(CLK_HALF)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .ack_o     (ack_o),
   .mdc_o     (mdc_o),
   .mdio_o    (mdio_o),
   .mdio_oe_o (mdio_oe_o),
   .mdio_i    (mdio_i)
);

// File: tb/test_mdio_frame_engine.sv
`timescale 1ns/1ps
module test_mdio_frame_engine;

   localparam int HALF = 2;
   localparam int PRE  = 32;
   localparam int FW   = 64;
   localparam logic [63:0] RD_OE_MASK = 64'hFFFF_FFFF_FFFC_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        rd_i = 1'b0;
   logic [4:0]  phy_addr_i = '0;
   logic [4:0]  reg_addr_i = '0;
   logic [15:0] wdata_i = '0;
   logic        busy_o, done_o, ack_o, mdc_o, mdio_o, mdio_oe_o;
   logic [15:0] rdata_o;
   logic        mdio_i = 1'b1;

   int vectors = 0;
   int fails   = 0;
   int cycles  = 0;

   // PHY model / monitor state
   logic        cap [0:FW-1];
   logic        oer [0:FW-1];
   int          bidx = 0;
   int          rises = 0;
   int          dones = 0;
   int          hi_bad = 0;
   int          hi_run = 0;
   int          glitch = 0;
   logic        busy_q = 1'b0, mdc_q = 1'b0, mdio_q = 1'b1;
   logic        resp_en = 1'b0;
   logic        resp_ta2 = 1'b1;
   logic [15:0] resp_data = '0;

   always #2.5 clk = ~clk;

   mdio_frame_engine #(.CLK_HALF(HALF), .PRE_LEN(PRE)) i_mdio_frame_engine (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
      .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
      .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o), .ack_o(ack_o),
      .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (busy_o && !busy_q) begin
            bidx  = 0;
            rises = 0;
         end
         if (mdc_o && !mdc_q) begin
            if (bidx < FW) begin
               cap[bidx] = mdio_o;
               oer[bidx] = mdio_oe_o;
            end
            rises++;
         end
         if (mdc_o) hi_run++;
         else begin
            if (mdc_q && hi_run != HALF) hi_bad++;
            hi_run = 0;
         end
         if (busy_o && mdio_oe_o && mdc_o && mdc_q && (mdio_o != mdio_q)) glitch++;
         if (!mdc_o && mdc_q) bidx++;
         if (done_o) dones++;
      end
      if (!resp_en)                 mdio_i = 1'b1;
      else if (bidx == 47)          mdio_i = resp_ta2;
      else if (bidx >= 48 && bidx < 64) mdio_i = resp_data[63-bidx];
      else                          mdio_i = 1'b1;
      busy_q = busy_o;
      mdc_q  = mdc_o;
      mdio_q = mdio_o;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL R8 watchdog: actual cycles %0d expected under 150000", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] cap_vec();
      logic [63:0] v;
      for (int i = 0; i < FW; i++) v[63-i] = cap[i];
      return v;
   endfunction

   function automatic logic [63:0] oe_vec();
      logic [63:0] v;
      for (int i = 0; i < FW; i++) v[63-i] = oer[i];
      return v;
   endfunction

   function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] pa,
                                             input logic [4:0] ra, input logic [15:0] wd);
      return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, pa, ra,
              rd ? 2'b00 : 2'b10, rd ? 16'h0000 : wd};
   endfunction

   task automatic launch(input logic rd, input logic [4:0] pa,
                         input logic [4:0] ra, input logic [15:0] wd);
      rd_i = rd; phy_addr_i = pa; reg_addr_i = ra; wdata_i = wd;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done();
      for (int k = 0; k < 4000 && !(dones > 0 && !busy_o); k++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      chk(!busy_o && !done_o && !mdc_o && !mdio_oe_o, "R1 idle outputs after reset",
          {60'd0, busy_o, done_o, mdc_o, mdio_oe_o}, 64'd0);
      chk(!ack_o && rdata_o == 16'h0, "R1 ack/rdata after reset",
          {47'd0, ack_o, rdata_o}, 64'd0);
   endtask

   task automatic t_write(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
      logic [15:0] rd_before;
      rd_before = rdata_o;
      dones = 0; hi_bad = 0; glitch = 0; resp_en = 1'b0;
      @(negedge clk);
      launch(1'b0, pa, ra, wd);
      wait_done();
      chk(cap_vec()[63:18] == exp_frame(1'b0, pa, ra, wd)[63:18],
          "R2 write header fields", cap_vec(), exp_frame(1'b0, pa, ra, wd));
      chk(cap_vec()[17:0] == exp_frame(1'b0, pa, ra, wd)[17:0],
          "R3 write turnaround and data", cap_vec(), exp_frame(1'b0, pa, ra, wd));
      chk(oe_vec() == 64'hFFFF_FFFF_FFFF_FFFF, "R3 write drive enable",
          oe_vec(), 64'hFFFF_FFFF_FFFF_FFFF);
      chk(rises == FW && hi_bad == 0 && glitch == 0, "R7 clock shape / data on fall",
          {rises, hi_bad[15:0], glitch[15:0]}, {FW, 32'd0});
      chk(dones == 1 && !busy_o && !mdio_oe_o, "R8 single done, line released",
          {dones, 30'd0, busy_o, mdio_oe_o}, {32'd1, 32'd0});
      chk(rdata_o == rd_before && !ack_o, "R11 write leaves rdata, ack low",
          {47'd0, ack_o, rdata_o}, {47'd0, 1'b0, rd_before});
   endtask

   task automatic t_read(input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] d, input logic ta2);
      dones = 0; resp_en = 1'b1; resp_ta2 = ta2; resp_data = d;
      @(negedge clk);
      launch(1'b1, pa, ra, 16'hFFFF);
      wait_done();
      resp_en = 1'b0;
      chk((cap_vec() & RD_OE_MASK) == (exp_frame(1'b1, pa, ra, 16'h0) & RD_OE_MASK),
          "R2 read header fields", cap_vec() & RD_OE_MASK,
          exp_frame(1'b1, pa, ra, 16'h0) & RD_OE_MASK);
      chk(oe_vec() == RD_OE_MASK, "R4 read releases at turnaround", oe_vec(), RD_OE_MASK);
      chk(rdata_o == d, "R5 read data MSB first", {48'd0, rdata_o}, {48'd0, d});
      chk(ack_o == !ta2, "R6 ack from second turnaround bit",
          {63'd0, ack_o}, {63'd0, !ta2});
   endtask

   task automatic t_busy_start();
      dones = 0; resp_en = 1'b0;
      @(negedge clk);
      launch(1'b0, 5'h0C, 5'h03, 16'h1234);
      repeat (40) @(negedge clk);
      launch(1'b1, 5'h13, 5'h1C, 16'hFFFF);
      repeat (60) @(negedge clk);
      launch(1'b1, 5'h01, 5'h02, 16'hFFFF);
      wait_done();
      chk(cap_vec() == exp_frame(1'b0, 5'h0C, 5'h03, 16'h1234),
          "R9 frame unchanged by start while busy", cap_vec(),
          exp_frame(1'b0, 5'h0C, 5'h03, 16'h1234));
      repeat (20) @(negedge clk);
      chk(dones == 1 && !busy_o, "R9 no extra frame from ignored start",
          {dones, 31'd0, busy_o}, {32'd1, 32'd0});
   endtask

   task automatic t_back_to_back();
      dones = 0; resp_en = 1'b0;
      @(negedge clk);
      launch(1'b0, 5'h1E, 5'h11, 16'hBEEF);
      for (int k = 0; k < 4000 && !done_o; k++) @(negedge clk);
      rd_i = 1'b1; phy_addr_i = 5'h07; reg_addr_i = 5'h19; wdata_i = 16'h0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1 && dones == 1, "R10 start in done cycle accepted",
          {dones, 31'd0, busy_o}, {32'd1, 32'd1});
      dones = 0;
      resp_en = 1'b1; resp_ta2 = 1'b0; resp_data = 16'h8001;
      wait_done();
      resp_en = 1'b0;
      chk((cap_vec() & RD_OE_MASK) == (exp_frame(1'b1, 5'h07, 5'h19, 16'h0) & RD_OE_MASK),
          "R10 second frame carries new request", cap_vec() & RD_OE_MASK,
          exp_frame(1'b1, 5'h07, 5'h19, 16'h0) & RD_OE_MASK);
      chk(rdata_o == 16'h8001 && ack_o, "R5 back-to-back read result",
          {47'd0, ack_o, rdata_o}, {47'd0, 1'b1, 16'h8001});
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write(5'h15, 5'h0A, 16'hA55A);
      t_write(5'h00, 5'h1F, 16'h0001);
      t_read(5'h1F, 5'h01, 16'hC3A5, 1'b0);
      t_write(5'h0B, 5'h04, 16'hFFFE);
      t_read(5'h02, 5'h10, 16'h5A0F, 1'b1);
      t_busy_start();
      t_back_to_back();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule